// File: doc/BRIEF.md
# Vector Complex Add-Rotate Unit

This datapath unit adds two 128-bit vectors that hold complex numbers. Real and imaginary parts sit in alternating lanes, and the second operand is rotated by 90 or 270 degrees during the add. Each lane of the first source is paired with the neighbouring lane of the second source. One rotation makes the even lanes subtract and the odd lanes add. The other rotation swaps those two roles.

A 16-bit predicate, one bit per byte, merges the new lane results into the previous destination value. A cleared bit keeps the old byte. The lane width comes from a 2-bit size code: 8, 16 or 32 bits. The fourth size code belongs to a different operation, so the unit refuses it and raises a flag instead of writing a result.

The unit takes one request per cycle, marked by a valid strobe, and presents a registered result on the following cycle. Every lane result is formed from the inputs as they were presented. For that reason the merge is correct even when the old destination value is the same vector as the second source.

Top module: `cplx_rot_add`

## Requirements
- R1: Size code 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. At lane size S bytes, lane i occupies result bytes i*S to i*S+S-1, and lane 0 is in bits [8*S-1:0].
- R2: An even lane e combines lane e of the first source with lane e+1 of the second source. An odd lane e combines lane e of the first source with lane e-1 of the second source.
- R3: When the rotation input is 0 (90 degrees), even lanes compute first minus second and odd lanes compute first plus second.
- R4: When the rotation input is 1 (270 degrees), even lanes compute first plus second and odd lanes compute first minus second.
- R5: Every lane sum and difference wraps modulo 2 to the power of the lane width, with no saturation and no carry into a neighbouring lane.
- R6: Predicate bit b governs result bits [8b+7:8b]. When the bit is 1 the byte takes the new value. When the bit is 0 the byte keeps the old destination byte. A predicate of zero returns the old destination unchanged.
- R7: Results are computed only from the operands presented in the request cycle, so they are correct when the old destination equals the second source at every lane size.
- R8: A request with size code 2'b11 drives the illegal-size flag high on the next cycle. On that cycle the valid output stays low and the result output keeps its previous value.
- R9: A request with a legal size drives the valid output high on the next cycle, with the merged result. A cycle with no request leaves both the valid output and the flag low on the next cycle.
- R10: While reset is asserted, the valid output, the flag and the result output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Request strobe |
| i_size | input | 2 | Lane size code |
| i_rot270 | input | 1 | 0 selects 90-degree rotation, 1 selects 270-degree rotation |
| i_src_n | input | 128 | First source vector |
| i_src_m | input | 128 | Second source vector |
| i_dst_old | input | 128 | Previous destination value |
| i_pred | input | 16 | Per-byte write predicate |
| o_valid | output | 1 | Result valid, one cycle after the request |
| o_illegal | output | 1 | Refused size code, one cycle after the request |
| o_result | output | 128 | Merged destination value |

## Verification
The hardest case to reach from the ports is a request whose old destination is the second source itself. A design that updates lanes in place would read already-rewritten neighbour lanes, and ordinary stimulus never exposes that. The stimulus creates the case directly by driving the same random vector onto the second-source and old-destination inputs, at every lane size and for both rotations, with random predicates. Lane-boundary wrap is forced with saturated byte patterns such as 0x80 minus 0x01 and 0xFF plus 0x01. These patterns show up a carry or borrow leaking into the next lane.

// File: rtl/cra_pkg.sv
package cra_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } cra_size_e;

  localparam int unsigned CRA_NUM_SIZES = 3;
endpackage

// File: rtl/cra_lane_alu.sv
// Computes the rotated complex add for one lane width across the whole vector.
module cra_lane_alu #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [VEC_W-1:0] src_n,
  input  logic [VEC_W-1:0] src_m,
  input  logic             rot270,
  output logic [VEC_W-1:0] res
);
  localparam int unsigned LANES = VEC_W / ELEM_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned PARTNER = (g % 2 == 0) ? g + 1 : g - 1;
    localparam bit          IS_EVEN = (g % 2 == 0);

    logic              do_sub;
    logic [ELEM_W-1:0] a_op;
    logic [ELEM_W-1:0] b_op;
    logic [ELEM_W-1:0] b_adj;

    always_comb begin
      // even lanes subtract at 90 degrees, odd lanes subtract at 270
      do_sub = IS_EVEN ? ~rot270 : rot270;
      a_op   = src_n[g*ELEM_W +: ELEM_W];
      b_op   = src_m[PARTNER*ELEM_W +: ELEM_W];
      b_adj  = b_op ^ {ELEM_W{do_sub}};
      res[g*ELEM_W +: ELEM_W] = a_op + b_adj + {{(ELEM_W-1){1'b0}}, do_sub};
    end
  end
endmodule

// File: rtl/cra_byte_merge.sv
// Per-byte select between freshly computed lanes and the old destination.
module cra_byte_merge #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NBYTES = VEC_W / 8
) (
  input  logic [VEC_W-1:0]  fresh,
  input  logic [VEC_W-1:0]  old,
  input  logic [NBYTES-1:0] pred,
  output logic [VEC_W-1:0]  merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      merged[b*8 +: 8] = pred[b] ? fresh[b*8 +: 8] : old[b*8 +: 8];
    end
  end
endmodule

// File: rtl/cplx_rot_add.sv
module cplx_rot_add
  import cra_pkg::*;
#(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned MIN_ELEM = 8,
  localparam int unsigned NBYTES  = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [1:0]        i_size,
  input  logic              i_rot270,
  input  logic [VEC_W-1:0]  i_src_n,
  input  logic [VEC_W-1:0]  i_src_m,
  input  logic [VEC_W-1:0]  i_dst_old,
  input  logic [NBYTES-1:0] i_pred,
  output logic              o_valid,
  output logic              o_illegal,
  output logic [VEC_W-1:0]  o_result
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // one ALU per legal lane width
  logic [VEC_W-1:0] lane_res [CRA_NUM_SIZES];
  for (genvar k = 0; k < CRA_NUM_SIZES; k++) begin : g_size
    cra_lane_alu #(
      .VEC_W  (VEC_W),
      .ELEM_W (MIN_ELEM << k)
    ) u_alu (
      .src_n  (i_src_n),
      .src_m  (i_src_m),
      .rot270 (i_rot270),
      .res    (lane_res[k])
    );
  end

  cra_size_e        size_sel;
  logic             size_ok;
  logic [VEC_W-1:0] fresh;
  logic [VEC_W-1:0] merged;

  always_comb begin
    size_sel = cra_size_e'(i_size);
    size_ok  = (size_sel != SZ_RSVD);
    unique case (size_sel)
      SZ_BYTE: fresh = lane_res[0];
      SZ_HALF: fresh = lane_res[1];
      SZ_WORD: fresh = lane_res[2];
      default: fresh = '0;
    endcase
  end

  cra_byte_merge #(.VEC_W(VEC_W)) u_merge (
    .fresh  (fresh),
    .old    (i_dst_old),
    .pred   (i_pred),
    .merged (merged)
  );

  // next-state
  logic             valid_d, illegal_d, res_en;
  logic [VEC_W-1:0] result_d;
  always_comb begin
    valid_d   = i_valid & size_ok;
    illegal_d = i_valid & ~size_ok;
    res_en    = valid_d;
    result_d  = res_en ? merged : o_result;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      o_valid   <= 1'b0;
      o_illegal <= 1'b0;
      o_result  <= '0;
    end else begin
      o_valid   <= valid_d;
      o_illegal <= illegal_d;
      o_result  <= result_d;
    end
  end

  // assertions
  a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_valid && i_size != 2'b11) |=> o_valid && !o_illegal);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !i_valid |=> !o_valid && !o_illegal);

  a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_valid && i_size == 2'b11) |=> o_illegal && !o_valid);

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_valid && i_size == 2'b11) |=> $stable(o_result));

  a_r6_pred_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_valid && i_size != 2'b11 && i_pred == '0) |=> o_result == $past(i_dst_old));

  a_r3_word_lane0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_valid && i_size == 2'b10 && !i_rot270 && i_pred[3:0] == 4'hF)
      |=> o_result[31:0] == $past(i_src_n[31:0] - i_src_m[63:32]));

  a_r4_word_lane0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (i_valid && i_size == 2'b10 && i_rot270 && i_pred[3:0] == 4'hF)
      |=> o_result[31:0] == $past(i_src_n[31:0] + i_src_m[63:32]));
endmodule

// File: tb/cplx_rot_add_tb.sv
module cplx_rot_add_tb;
  logic         clk;
  logic         rst_n;
  logic         i_valid;
  logic [1:0]   i_size;
  logic         i_rot270;
  logic [127:0] i_src_n, i_src_m, i_dst_old;
  logic [15:0]  i_pred;
  logic         o_valid, o_illegal;
  logic [127:0] o_result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  cplx_rot_add u_dut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_size(i_size),
    .i_rot270(i_rot270), .i_src_n(i_src_n), .i_src_m(i_src_m),
    .i_dst_old(i_dst_old), .i_pred(i_pred), .o_valid(o_valid),
    .o_illegal(o_illegal), .o_result(o_result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [1:0] sz, input logic rot,
      input logic [127:0] n, input logic [127:0] m, input logic [127:0] d,
      input logic [15:0] p);
    logic [127:0] r = '0;
    logic [127:0] msk;
    logic [127:0] out;
    int w = 8 << sz;
    int lanes = 128 / w;
    msk = (128'(1) << w) - 128'(1);
    for (int e = 0; e < lanes; e++) begin
      logic [127:0] a, b, v;
      int pe = (e % 2 == 0) ? e + 1 : e - 1;
      bit sub = (e % 2 == 0) ? !rot : rot;
      a = (n >> (e * w)) & msk;
      b = (m >> (pe * w)) & msk;
      v = (sub ? a - b : a + b) & msk;
      r = r | (v << (e * w));
    end
    for (int by = 0; by < 16; by++)
      out[by*8 +: 8] = p[by] ? r[by*8 +: 8] : d[by*8 +: 8];
    return out;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // drive at negedge, check at the next negedge
  task automatic op(input logic [1:0] sz, input logic rot, input logic [127:0] n,
      input logic [127:0] m, input logic [127:0] d, input logic [15:0] p,
      input string req);
    logic [127:0] exp;
    exp = model(sz, rot, n, m, d, p);
    i_valid = 1'b1; i_size = sz; i_rot270 = rot;
    i_src_n = n; i_src_m = m; i_dst_old = d; i_pred = p;
    @(negedge clk);
    i_valid = 1'b0;
    chk(o_valid === 1'b1 && o_illegal === 1'b0, {req, " R9 valid"},
        {126'd0, o_valid, o_illegal}, 128'd2);
    chk(o_result === exp, req, o_result, exp);
  endtask

  initial begin
    rst_n = 1'b0; i_valid = 1'b0; i_size = '0; i_rot270 = 1'b0;
    i_src_n = '0; i_src_m = '0; i_dst_old = '0; i_pred = '0;
    repeat (3) @(negedge clk);
    chk(o_valid === 1'b0 && o_illegal === 1'b0 && o_result === '0,
        "R10 reset state", o_result, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: directed lane pairing at each size
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 2; r++)
        op(2'(s), 1'(r), 128'h0f0e0d0c0b0a09080706050403020100,
           128'h10101010202020203030303040404040, '0, 16'hFFFF, "R1 R2 R3 R4 directed");

    // R5: wrap at lane boundaries
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 2; r++) begin
        op(2'(s), 1'(r), {16{8'h80}}, {16{8'h01}}, '0, 16'hFFFF, "R5 borrow wrap");
        op(2'(s), 1'(r), {16{8'hFF}}, {16{8'h01}}, '0, 16'hFFFF, "R5 carry wrap");
        op(2'(s), 1'(r), '0, {16{8'hFF}}, '0, 16'hFFFF, "R5 zero minus max");
      end

    // R6: predicate extremes and single-byte walk
    op(2'b00, 1'b0, rnd128(), rnd128(), rnd128(), 16'h0000, "R6 pred zero");
    for (int b = 0; b < 16; b++)
      op(2'(b % 3), 1'(b % 2), rnd128(), rnd128(), rnd128(), 16'(1 << b), "R6 single byte");

    // R3 R4 R6: random sweep per size and rotation
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 2; r++)
        for (int it = 0; it < 40; it++)
          op(2'(s), 1'(r), rnd128(), rnd128(), rnd128(), 16'($urandom()), "R3 R4 R6 random");

    // R7: old destination aliases second source
    for (int s = 0; s < 3; s++)
      for (int r = 0; r < 2; r++)
        for (int it = 0; it < 10; it++) begin
          logic [127:0] mm = rnd128();
          op(2'(s), 1'(r), rnd128(), mm, mm, 16'($urandom()), "R7 alias dst=m");
        end

    // R8: refused size code holds the result
    begin
      logic [127:0] held;
      op(2'b01, 1'b1, rnd128(), rnd128(), rnd128(), 16'hFFFF, "R8 setup");
      held = o_result;
      i_valid = 1'b1; i_size = 2'b11; i_src_n = rnd128(); i_src_m = rnd128();
      i_dst_old = rnd128(); i_pred = 16'hFFFF;
      @(negedge clk);
      i_valid = 1'b0;
      chk(o_illegal === 1'b1 && o_valid === 1'b0, "R8 flag",
          {126'd0, o_valid, o_illegal}, 128'd1);
      chk(o_result === held, "R8 result held", o_result, held);
      // R9: idle cycle
      @(negedge clk);
      chk(o_illegal === 1'b0 && o_valid === 1'b0, "R9 idle",
          {126'd0, o_valid, o_illegal}, 128'd0);
      chk(o_result === held, "R9 idle result held", o_result, held);
    end

    // back-to-back requests
    i_valid = 1'b1; i_size = 2'b10; i_rot270 = 1'b0;
    i_src_n = rnd128(); i_src_m = rnd128(); i_dst_old = rnd128(); i_pred = 16'hFFFF;
    begin
      logic [127:0] e1;
      e1 = model(2'b10, 1'b0, i_src_n, i_src_m, i_dst_old, i_pred);
      @(negedge clk);
      chk(o_valid === 1'b1 && o_result === e1, "R9 back-to-back first", o_result, e1);
    end
    op(2'b00, 1'b1, rnd128(), rnd128(), rnd128(), 16'hA5A5, "R9 back-to-back second");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule